// File: doc/BRIEF.md
# Three-Level PWM Input Classifier

This block turns a PWM line that can sit at three levels (driven high, driven low, or parked at a middle voltage) into a clean command bit and a shutdown flag for a power-stage gate controller. The analog front end compares the line against four thresholds and hands the block a four-bit thermometer code that is already synchronized to the clock. The block decides, on every clock, which region the line is in and updates its two outputs.

A high or low level is passed on as the PWM command at the next clock edge and clears any shutdown. A middle level is only trusted after the line has stayed there for a programmable number of consecutive clock cycles; a shorter visit leaves the previous command untouched. The regions between the middle window and the high or low levels act as hysteresis bands in which nothing changes. An undriven line floats into the middle window, so a controller that stops driving ends in shutdown. Out of reset the block reports shutdown until it sees a real high or low level.

Top module: `pwm3_level_classifier`

## Requirements
- R1: During and directly after reset, `shutdown` is 1 and `pwm_cmd` is 0.
- R2: A sampled `lvl_code` of 4'b1111 (line above the high level) makes `pwm_cmd` 1 and `shutdown` 0 at the next clock edge.
- R3: A sampled `lvl_code` of 4'b0000 (line below the low level) makes `pwm_cmd` 0 and `shutdown` 0 at the next clock edge.
- R4: When `lvl_code` is 4'b0011 (inside the middle window) for N consecutive samples, N being `hold_limit`, `shutdown` becomes 1 at the edge that takes the N-th sample; `pwm_cmd` keeps its value.
- R5: A run of fewer than N consecutive window samples leaves `shutdown` and `pwm_cmd` unchanged.
- R6: The band codes 4'b0001 (between low level and window) and 4'b0111 (between window and high level) leave both outputs unchanged and restart the window count, so window runs split by a band do not add up.
- R7: Any code that is not one of 4'b0000, 4'b0001, 4'b0011, 4'b0111, 4'b1111 is treated like a band: outputs held, window count restarted.
- R8: Once in shutdown, the first high or low sample clears `shutdown` and sets `pwm_cmd` to the new level at the next edge.
- R9: The window count saturates, so an arbitrarily long window stay keeps `shutdown` at 1; a `hold_limit` of 0 behaves as 1.
- R10: A line left in the middle window from reset onwards keeps `shutdown` at 1 and `pwm_cmd` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_code | input | 4 | Thermometer code: bit 3 above high level, bit 2 above window top, bit 1 above window bottom, bit 0 above low level |
| hold_limit | input | CNT_W | Window hold-off in clock cycles |
| pwm_cmd | output | 1 | Decided PWM command |
| shutdown | output | 1 | Both switches must be off |

## Verification
The hold-off expiry and an exit from the window can land on neighbouring edges, so a window stay of exactly `hold_limit` samples followed at once by a high or low sample is driven: shutdown must show for one cycle and then clear with the new command. The same exit after `hold_limit - 1` samples must show no shutdown at all, which pins the expiry to the right edge. A band or an invalid code inserted one sample before expiry is also driven to show that the count restarts rather than pausing.

// File: rtl/pwm3_cls_pkg.sv
package pwm3_cls_pkg;

    typedef enum logic [2:0] {
        ZN_LOW     = 3'd0,
        ZN_BAND_LO = 3'd1,
        ZN_WIN     = 3'd2,
        ZN_BAND_HI = 3'd3,
        ZN_HIGH    = 3'd4,
        ZN_BAD     = 3'd5
    } zone_e;

    typedef struct packed {
        logic cmd;
        logic shut;
    } drv_s;

    localparam logic [3:0] CODE_LOW     = 4'b0000;
    localparam logic [3:0] CODE_BAND_LO = 4'b0001;
    localparam logic [3:0] CODE_WIN     = 4'b0011;
    localparam logic [3:0] CODE_BAND_HI = 4'b0111;
    localparam logic [3:0] CODE_HIGH    = 4'b1111;

    localparam drv_s DRV_RESET = '{cmd: 1'b0, shut: 1'b1};

    function automatic zone_e classify(input logic [3:0] code);
        zone_e z;
        case (code)
            CODE_LOW:     z = ZN_LOW;
            CODE_BAND_LO: z = ZN_BAND_LO;
            CODE_WIN:     z = ZN_WIN;
            CODE_BAND_HI: z = ZN_BAND_HI;
            CODE_HIGH:    z = ZN_HIGH;
            default:      z = ZN_BAD;
        endcase
        return z;
    endfunction

    function automatic logic is_hold_zone(input zone_e z);
        return (z == ZN_BAND_LO) || (z == ZN_BAND_HI) || (z == ZN_BAD);
    endfunction

endpackage

// File: rtl/pwm3_zone_decode.sv
module pwm3_zone_decode
    import pwm3_cls_pkg::*;
(
    input  logic [3:0] lvl_code,
    output zone_e      zone,
    output logic       in_win
);
    always_comb begin
        zone   = classify(lvl_code);
        in_win = (zone == ZN_WIN);
    end
endmodule

// File: rtl/pwm3_holdoff_timer.sv
module pwm3_holdoff_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_win,
    input  logic [CNT_W-1:0] hold_limit,
    output logic             expire
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_eff;
    logic [EXT_W-1:0] cnt_next_ext;

    always_comb begin
        lim_eff      = (hold_limit == '0) ? CNT_W'(1) : hold_limit;
        cnt_next_ext = {1'b0, cnt_q} + EXT_W'(1);
        expire       = in_win && (cnt_next_ext >= {1'b0, lim_eff});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!in_win) begin
            cnt_q <= '0;
        end else if (cnt_q < lim_eff) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        in_win |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))); // R9

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (rst)
        !in_win |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/pwm3_cmd_state.sv
module pwm3_cmd_state
    import pwm3_cls_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  zone_e zone,
    input  logic  expire,
    output logic  pwm_cmd,
    output logic  shutdown
);
    drv_s st_q;
    drv_s st_d;

    always_comb begin
        st_d = st_q;
        unique case (zone)
            ZN_HIGH: st_d = '{cmd: 1'b1, shut: 1'b0};
            ZN_LOW:  st_d = '{cmd: 1'b0, shut: 1'b0};
            ZN_WIN:  if (expire) st_d.shut = 1'b1;
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= DRV_RESET;
        else     st_q <= st_d;
    end

    assign pwm_cmd  = st_q.cmd;
    assign shutdown = st_q.shut;

    AST_HIGH_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (zone == ZN_HIGH) |=> (pwm_cmd && !shutdown)); // R2

    AST_LOW_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (zone == ZN_LOW) |=> (!pwm_cmd && !shutdown)); // R3

    AST_SHUT_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown) |-> $past(zone == ZN_WIN)); // R4

    AST_WIN_KEEPS_CMD: assert property (@(posedge clk) disable iff (rst)
        (zone == ZN_WIN) |=> $stable(pwm_cmd)); // R4

    AST_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
        is_hold_zone(zone) |=> ($stable(pwm_cmd) && $stable(shutdown))); // R6
endmodule

// File: rtl/pwm3_level_classifier.sv
module pwm3_level_classifier
    import pwm3_cls_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       lvl_code,
    input  logic [CNT_W-1:0] hold_limit,
    output logic             pwm_cmd,
    output logic             shutdown
);
    zone_e zone;
    logic  in_win;
    logic  expire;

    pwm3_zone_decode u_decode (
        .lvl_code (lvl_code),
        .zone     (zone),
        .in_win   (in_win)
    );

    pwm3_holdoff_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .in_win     (in_win),
        .hold_limit (hold_limit),
        .expire     (expire)
    );

    pwm3_cmd_state u_state (
        .clk      (clk),
        .rst      (rst),
        .zone     (zone),
        .expire   (expire),
        .pwm_cmd  (pwm_cmd),
        .shutdown (shutdown)
    );

    AST_BAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (zone == ZN_BAD) |=> ($stable(pwm_cmd) && $stable(shutdown))); // R7

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (shutdown && !pwm_cmd)); // R1
endmodule

// File: tb/pwm3_level_classifier_tb.sv
module pwm3_level_classifier_tb;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [3:0]       lvl_code = 4'b0011;
    logic [CNT_W-1:0] hold_limit = CNT_W'(16);
    logic             pwm_cmd;
    logic             shutdown;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    pwm3_level_classifier #(.CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .lvl_code   (lvl_code),
        .hold_limit (hold_limit),
        .pwm_cmd    (pwm_cmd),
        .shutdown   (shutdown)
    );

    task automatic check(input string req, input logic exp_cmd, input logic exp_sh);
        n_checks++;
        if (pwm_cmd !== exp_cmd || shutdown !== exp_sh) begin
            n_fails++;
            $display("FAIL %s: cmd=%b shutdown=%b expected cmd=%b shutdown=%b",
                     req, pwm_cmd, shutdown, exp_cmd, exp_sh);
        end
    endtask

    // drive a code at a falling edge and hold it for n rising edges
    task automatic apply(input logic [3:0] code, input int n);
        lvl_code = code;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset_float();
        @(negedge clk);
        check("R1 in reset", 1'b0, 1'b1);
        apply(4'b0011, 2);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 1'b0, 1'b1);
        apply(4'b0011, 40);
        check("R10 floating line", 1'b0, 1'b1);
    endtask

    task automatic t_levels();
        apply(4'b1111, 1);
        check("R2 high level", 1'b1, 1'b0);
        apply(4'b0000, 1);
        check("R3 low level", 1'b0, 1'b0);
        apply(4'b1111, 1);
        check("R2 high again", 1'b1, 1'b0);
    endtask

    task automatic t_short_window();
        apply(4'b0011, 15);
        check("R5 window one short", 1'b1, 1'b0);
        apply(4'b1111, 1);
        check("R5 exit before expiry", 1'b1, 1'b0);
    endtask

    task automatic t_exact_window();
        apply(4'b0011, 15);
        check("R4 before expiry", 1'b1, 1'b0);
        apply(4'b0011, 1);
        check("R4 expiry keeps cmd", 1'b1, 1'b1);
        apply(4'b0000, 1);
        check("R8 exit to low", 1'b0, 1'b0);
        apply(4'b0011, 16);
        check("R4 expiry from low", 1'b0, 1'b1);
        apply(4'b1111, 1);
        check("R8 exit to high", 1'b1, 1'b0);
    endtask

    task automatic t_bands();
        apply(4'b0011, 15);
        apply(4'b0001, 1);
        check("R6 low band hold", 1'b1, 1'b0);
        apply(4'b0011, 15);
        check("R6 count restarted", 1'b1, 1'b0);
        apply(4'b0111, 1);
        apply(4'b0011, 15);
        check("R6 upper band restart", 1'b1, 1'b0);
        apply(4'b0000, 1);
        apply(4'b0111, 5);
        check("R6 upper band keeps low", 1'b0, 1'b0);
        apply(4'b0011, 16);
        apply(4'b0001, 3);
        check("R6 band keeps shutdown", 1'b0, 1'b1);
        apply(4'b0000, 1);
    endtask

    task automatic t_invalid();
        apply(4'b1111, 1);
        apply(4'b0011, 15);
        apply(4'b0101, 1);
        check("R7 invalid code hold", 1'b1, 1'b0);
        apply(4'b0011, 15);
        check("R7 count restarted", 1'b1, 1'b0);
        apply(4'b1000, 1);
        check("R7 second invalid code", 1'b1, 1'b0);
    endtask

    task automatic t_saturate();
        apply(4'b0000, 1);
        apply(4'b0011, 300);
        check("R9 long window stays", 1'b0, 1'b1);
        apply(4'b1111, 1);
        check("R8 exit after long stay", 1'b1, 1'b0);
        hold_limit = '0;
        apply(4'b0011, 1);
        check("R9 zero limit acts as one", 1'b1, 1'b1);
        apply(4'b0000, 1);
        hold_limit = CNT_W'(1);
        apply(4'b0011, 1);
        check("R9 limit of one", 1'b0, 1'b1);
        apply(4'b0000, 1);
        hold_limit = CNT_W'(16);
    endtask

    initial begin
        t_reset_float();
        t_levels();
        t_short_window();
        t_exact_window();
        t_bands();
        t_invalid();
        t_saturate();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule